// File: doc/BRIEF.md
# Sticky Supply Fault Status Register

This block keeps a record of which of four supervised supply sources have failed since software last armed it. Each source has one flag bit. A flag is active-low: it reads 1 while the source has been fine since arming, and it drops to 0 when that source reports a failure. Once a flag drops, it stays at 0 until software writes a 1 to it again.

At reset every flag is 0, so the register holds no useful information until software arms it by writing 0Fh. After a system reset, software reads the register to find out which source caused the trouble. It then writes ones back to re-arm the flags before the next fault.

Each flag is a two-state machine. `ST_CLEAR` reads 0 and `ST_ARMED` reads 1. The transitions are:
- ARM: `ST_CLEAR` to `ST_ARMED`, on a write of 1 with no failure present.
- TRIP: `ST_ARMED` to `ST_CLEAR`, on a failure.
- DISARM: `ST_ARMED` to `ST_CLEAR`, on a write of 0.
- HOLD: the state does not change in any other cycle.

The register sits behind a single-cycle write port and a continuously driven read port. The read port has no strobe, so reading has no side effect.

Top module: `fault_latch_reg`

## Requirements
- R1: After reset, every flag is 0 and `rd_data` reads 00h.
- R2: A write (`wr_en`=1) with `wr_data[i]`=1 and `src_fail[i]`=0 makes flag i read 1 after the next rising clock edge (ARM).
- R3: `src_fail[i]`=1 at a rising edge makes flag i read 0 after that edge (TRIP). The flag stays 0 after `src_fail[i]` returns to 0, until it is re-armed.
- R4: If `src_fail[i]`=1 and a write of 1 to flag i fall in the same cycle, the failure wins and flag i reads 0. While the failure persists, writes of 1 leave the flag at 0.
- R5: A write with `wr_data[i]`=0 forces flag i to 0 (DISARM).
- R6: `rd_data[3:0]` holds flags 3..0, with flag i on bit i. `rd_data[7:4]` always reads 0. The value can be read in any cycle and reading changes nothing.
- R7: `wr_data[7:4]` has no effect on any flag.
- R8: With `wr_en`=0 and no failure on source i, flag i keeps its value (HOLD). The four flags act independently of one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 8 | Write data; only bits 3..0 are used |
| src_fail | input | 4 | Per-source failure indication, level or pulse |
| rd_data | output | 8 | Current flags on bits 3..0, zeros above |

## Verification
Directed sequences cover these cases:
- Arming from the all-zero reset state.
- A single-cycle failure pulse, which shows the flag is sticky rather than a copy of the level.
- A write of 1 in the same cycle as a failure, and a held failure under repeated re-arm writes, which show the failure has priority.
- A write of 0, which shows that disarming is separate from tripping.
- Writes with junk in the upper data nibble, which show the upper bits are ignored.

A long random mix of writes and failures per bit then exercises all transitions together against a bench model. That pass separates per-bit independence from any cross-coupling between flags.

// File: rtl/fault_latch_pkg.sv
package fault_latch_pkg;
    localparam int unsigned N_SRC  = 4;
    localparam int unsigned DATA_W = 8;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_ARMED = 1'b1
    } flag_state_e;
endpackage

// File: rtl/fault_flag_cell.sv
module fault_flag_cell
    import fault_latch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic fail,
    output logic flag
);
    flag_state_e state_q;
    flag_state_e state_d;

    // next-state selection: failure (TRIP) has priority over any write
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (!fail && wr_en && wr_bit) state_d = ST_ARMED;   // ARM
            end
            ST_ARMED: begin
                if (fail)                      state_d = ST_CLEAR;  // TRIP
                else if (wr_en && !wr_bit)     state_d = ST_CLEAR;  // DISARM
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == ST_ARMED);
    end

    // R2
    arm_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bit && !fail) |=> flag);
    // R3
    trip_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !flag);
    // R4
    fail_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && wr_en && wr_bit) |=> !flag);
    // R5
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bit) |=> !flag);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !fail) |=> $stable(flag));
endmodule

// File: rtl/fault_rd_fmt.sv
module fault_rd_fmt #(
    parameter int unsigned N_SRC  = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic [N_SRC-1:0]  flags,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned PAD_W = DATA_W - N_SRC;

    always_comb begin
        rd_data = {{PAD_W{1'b0}}, flags};
    end

    // R6
    always_comb begin
        upper_zero_chk: assert (rd_data[DATA_W-1:N_SRC] == '0);
    end
endmodule

// File: rtl/fault_latch_reg.sv
module fault_latch_reg
    import fault_latch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [N_SRC-1:0]  src_fail,
    output logic [DATA_W-1:0] rd_data
);
    logic [N_SRC-1:0] flags;

    for (genvar g = 0; g < N_SRC; g++) begin : g_flag
        fault_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en),
            .wr_bit (wr_data[g]),
            .fail   (src_fail[g]),
            .flag   (flags[g])
        );
    end

    fault_rd_fmt #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_fmt (
        .flags   (flags),
        .rd_data (rd_data)
    );

    // R7: the upper write nibble never raises a flag without an armed low bit
    upper_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[N_SRC-1:0] == '0) |=> (rd_data == '0));
endmodule

// File: tb/fault_latch_reg_tb.sv
module fault_latch_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] src_fail = 4'h0;
    logic [7:0] rd_data;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [3:0] model = 4'h0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fault_latch_reg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_data(wr_data), .src_fail(src_fail), .rd_data(rd_data)
    );

    function automatic logic [3:0] next_flags(input logic [3:0] cur, input logic we,
                                              input logic [7:0] d, input logic [3:0] f);
        logic [3:0] n;
        n = we ? d[3:0] : cur;
        return n & ~f;
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%02h expected=%02h", req, rd_data, exp);
        end
    endtask

    // apply one cycle of stimulus, then check shortly after the edge
    task automatic step(input string req, input logic we, input logic [7:0] d, input logic [3:0] f);
        wr_en = we; wr_data = d; src_fail = f;
        @(posedge clk);
        model = next_flags(model, we, d, f);
        #1;
        check(req, {4'h0, model});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: rd_data=%02h expected=run end", rd_data);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'd1357;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        step("R1 idle after reset", 1'b0, 8'h00, 4'h0);
        step("R2 arm all", 1'b1, 8'h0F, 4'h0);
        step("R8 hold", 1'b0, 8'h00, 4'h0);
        step("R3 trip bit1", 1'b0, 8'h00, 4'h2);
        step("R3 sticky after pulse", 1'b0, 8'h00, 4'h0);
        step("R6 read again no side effect", 1'b0, 8'h00, 4'h0);
        step("R2 rearm", 1'b1, 8'h0F, 4'h0);
        step("R4 fail wins same cycle", 1'b1, 8'h0F, 4'h8);
        step("R4 held fail blocks rearm", 1'b1, 8'h0F, 4'h8);
        step("R4 released then rearm", 1'b1, 8'h0F, 4'h0);
        step("R5 disarm bits 0,2", 1'b1, 8'h0A, 4'h0);
        step("R7 upper nibble ignored", 1'b1, 8'hF0, 4'h0);
        step("R7 upper nibble with arm", 1'b1, 8'hA5, 4'h0);
        step("R8 independent trip bit0", 1'b0, 8'h00, 4'h1);
        for (int i = 0; i < 3000; i++) begin
            logic       we;
            logic [7:0] d;
            logic [3:0] f;
            we = ($urandom % 3) != 0;
            d  = 8'($urandom);
            f  = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
            step("R8 random mix", we, d, f);
            n_chk++;
            if (rd_data[7:4] !== 4'h0) begin
                n_bad++;
                $display("FAIL R6 upper: rd_data=%02h expected=0x", rd_data);
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule